// File: doc/BRIEF.md
# Constant-Load Instruction Pair Rewriter

This block sits in a stream of 32-bit RISC-V instruction words. It looks for a load-upper-immediate instruction that is followed at once by an add-immediate instruction writing the same register and reading it back. When it finds such a pair, it rewrites the immediates of both words. After the pair runs, the register holds a new 32-bit constant taken from a configuration input. All other bits of the two words are kept. Every other word, including words that hold 16-bit compressed instructions, passes through untouched and in order, together with its address.

Words enter and leave through valid/ready handshakes. An end-of-stream marker closes each stream. At the end of each stream the block reports one of two results: a pair was rewritten, or no pair was found. The output also gives a little-endian byte view of each word. A readback checker compares the two rewritten words as they leave the block against the values that were computed for them, and raises an error flag on any difference.

Top module: `const_pair_rewriter`

## Requirements
- R1: For target T, the rewritten upper-immediate word carries T[31:12] + T[11] modulo 2^20 in bits [31:12], and the rewritten add-immediate word carries T[11:0] in bits [31:20]. Example: T=0xbc0c3e01 turns 0xac0c27b7 into 0xbc0c47b7 and turns 0xe0978793 into 0xe0178793. T=0xfffff800 wraps the upper field to 0x00000.
- R2: In a rewritten pair, only the immediate fields change. Bits [11:0] of the upper-immediate word and bits [19:0] of the add-immediate word leave exactly as they came in.
- R3: A pair is a word with opcode bits [6:0]=0x37 followed directly by a word with bits [6:0]=0x13 and bits [14:12]=0. In the second word, the destination field [11:7] and the source field [19:15] must both equal the first word's destination field [11:7]. A different register, a different funct3, or any word between the two means there is no pair.
- R4: Only the first pair in a stream is rewritten. Later pairs in the same stream pass unchanged.
- R5: All words that are not part of the rewritten pair leave unchanged, in input order, with their own address and end marker. This includes words whose bits [1:0] are not 3. A pair never spans the end of one stream and the start of the next.
- R6: out_le holds the output word byte-reversed, so the lowest-addressed byte sits in bits [31:24]. For example, 0x200109b7 appears as 0xb7090120.
- R7: Once the last word of a stream is accepted, exactly one flag is raised. patch_done is raised if a pair was rewritten in that stream, and not_found is raised otherwise. Both flags hold until the first word of the next stream is accepted, and then both clear.
- R8: verify_err rises only if a rewritten word leaves the block with a value other than the one computed for it. In normal operation it stays low.
- R9: While out_valid is high and out_ready is low, out_valid, out_word, out_addr and out_last hold steady. No word is lost or duplicated under backpressure.
- R10: During reset, out_valid, patch_done, not_found and verify_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_target | input | 32 | Constant that the rewritten pair must build |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_word | input | 32 | Input instruction word |
| in_addr | input | ADDR_W | Address of the input word |
| in_last | input | 1 | Input word ends the stream |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_word | output | 32 | Output instruction word |
| out_le | output | 32 | Output word in little-endian byte order |
| out_addr | output | ADDR_W | Address of the output word |
| out_last | output | 1 | Output word ends the stream |
| patch_done | output | 1 | The last stream had a pair rewritten |
| not_found | output | 1 | The last stream ended with no pair |
| verify_err | output | 1 | A rewritten word left with the wrong value |

## Verification
The hardest cases to reach are the near-misses and the boundary cases. In one, an upper-immediate word is the last word of one stream and a matching add-immediate word opens the next, so a pair seems to span the boundary. In another, the output stalls just as the second word of the pair arrives. The stimulus builds such streams on purpose: mismatched registers, a wrong funct3, a word in between, two pairs in one stream, a pair split by the end marker, and a pair that ends the stream. It then runs randomly generated streams with planted pairs while out_ready is toggled at random. Each word is checked against a reference built from the requirements.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int WORD_W  = 32;
  localparam int NBYTES  = WORD_W / 8;
  localparam int UP_W    = 20;
  localparam int LO_W    = WORD_W - UP_W;
  localparam logic [6:0] OPC_UPPER = 7'h37;
  localparam logic [6:0] OPC_ADDIMM = 7'h13;

  function automatic logic is_upper(input logic [WORD_W-1:0] w);
    return w[6:0] == OPC_UPPER;
  endfunction

  function automatic logic is_addimm(input logic [WORD_W-1:0] w);
    return (w[6:0] == OPC_ADDIMM) && (w[14:12] == 3'd0);
  endfunction
endpackage

// File: rtl/cpr_pair_detect.sv
module cpr_pair_detect
  import cpr_pkg::*;
(
  input  logic              arm,
  input  logic [WORD_W-1:0] prev_word,
  input  logic [WORD_W-1:0] next_word,
  output logic              hit
);
  logic [4:0] dst_reg;
  always_comb begin
    dst_reg = prev_word[11:7];
    hit = arm && is_upper(prev_word) && is_addimm(next_word)
          && (next_word[11:7] == dst_reg) && (next_word[19:15] == dst_reg);
  end
endmodule

// File: rtl/cpr_imm_encoder.sv
module cpr_imm_encoder
  import cpr_pkg::*;
(
  input  logic [WORD_W-1:0] target,
  input  logic [WORD_W-1:0] upper_in,
  input  logic [WORD_W-1:0] addimm_in,
  output logic [WORD_W-1:0] upper_out,
  output logic [WORD_W-1:0] addimm_out
);
  logic [UP_W-1:0] up_part;
  logic [LO_W-1:0] lo_part;
  always_comb begin
    lo_part = target[LO_W-1:0];
    // the low part is sign extended when added, so bias the upper part
    up_part = target[WORD_W-1:LO_W] + {{(UP_W-1){1'b0}}, lo_part[LO_W-1]};
    upper_out  = {up_part, upper_in[LO_W-1:0]};
    addimm_out = {lo_part, addimm_in[WORD_W-LO_W-1:0]};
  end
endmodule

// File: rtl/cpr_readback_check.sv
module cpr_readback_check
  import cpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [WORD_W-1:0] exp_upper,
  input  logic [WORD_W-1:0] exp_addimm,
  input  logic              out_fire,
  input  logic [WORD_W-1:0] out_word,
  output logic              err
);
  logic              pend_up_q, pend_up_d;
  logic              pend_ad_q, pend_ad_d;
  logic [WORD_W-1:0] e_up_q, e_up_d;
  logic [WORD_W-1:0] e_ad_q, e_ad_d;
  logic              err_q, err_d;

  always_comb begin
    pend_up_d = pend_up_q;
    pend_ad_d = pend_ad_q;
    e_up_d    = e_up_q;
    e_ad_d    = e_ad_q;
    err_d     = err_q;
    if (out_fire) begin
      if (pend_up_q) begin
        err_d     = err_q | (out_word != e_up_q);
        pend_up_d = 1'b0;
      end else if (pend_ad_q) begin
        err_d     = err_q | (out_word != e_ad_q);
        pend_ad_d = 1'b0;
      end
    end
    if (capture) begin
      pend_up_d = 1'b1;
      pend_ad_d = 1'b1;
      e_up_d    = exp_upper;
      e_ad_d    = exp_addimm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_up_q <= 1'b0;
      pend_ad_q <= 1'b0;
      e_up_q    <= '0;
      e_ad_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      pend_up_q <= pend_up_d;
      pend_ad_q <= pend_ad_d;
      e_up_q    <= e_up_d;
      e_ad_q    <= e_ad_d;
      err_q     <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/const_pair_rewriter.sv
module const_pair_rewriter
  import cpr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_target,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [WORD_W-1:0] out_le,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_last,
  output logic              patch_done,
  output logic              not_found,
  output logic              verify_err
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  // hold stage (one word look-behind) and output stage
  logic              h_vld_q, h_vld_d, h_last_q, h_last_d;
  logic [WORD_W-1:0] h_word_q, h_word_d;
  logic [ADDR_W-1:0] h_addr_q, h_addr_d;
  logic              r_vld_q, r_vld_d, r_last_q, r_last_d;
  logic [WORD_W-1:0] r_word_q, r_word_d;
  logic [ADDR_W-1:0] r_addr_q, r_addr_d;
  logic              found_q, found_d, sof_q, sof_d;
  logic              done_q, done_d, nf_q, nf_d;

  logic              r_free, h_adv, in_fire, hit, arm;
  logic [WORD_W-1:0] new_upper, new_addimm;

  always_comb begin
    r_free   = !r_vld_q || out_ready;
    h_adv    = h_vld_q && (in_valid || h_last_q) && r_free;
    in_ready = !h_vld_q || h_adv;
    in_fire  = in_valid && in_ready;
    arm      = in_fire && h_vld_q && !h_last_q && !found_q;
  end

  cpr_pair_detect u_detect (
    .arm       (arm),
    .prev_word (h_word_q),
    .next_word (in_word),
    .hit       (hit)
  );

  cpr_imm_encoder u_encode (
    .target     (cfg_target),
    .upper_in   (h_word_q),
    .addimm_in  (in_word),
    .upper_out  (new_upper),
    .addimm_out (new_addimm)
  );

  always_comb begin
    h_vld_d  = h_vld_q;
    h_word_d = h_word_q;
    h_addr_d = h_addr_q;
    h_last_d = h_last_q;
    if (in_fire) begin
      h_vld_d  = 1'b1;
      h_word_d = hit ? new_addimm : in_word;
      h_addr_d = in_addr;
      h_last_d = in_last;
    end else if (h_adv) begin
      h_vld_d  = 1'b0;
    end

    r_vld_d  = r_vld_q;
    r_word_d = r_word_q;
    r_addr_d = r_addr_q;
    r_last_d = r_last_q;
    if (h_adv) begin
      r_vld_d  = 1'b1;
      r_word_d = hit ? new_upper : h_word_q;
      r_addr_d = h_addr_q;
      r_last_d = h_last_q;
    end else if (out_ready) begin
      r_vld_d  = 1'b0;
    end

    found_d = found_q;
    sof_d   = sof_q;
    done_d  = done_q;
    nf_d    = nf_q;
    if (in_fire) begin
      sof_d   = in_last;
      found_d = in_last ? 1'b0 : (found_q || hit);
      if (in_last) begin
        done_d = found_q || hit;
        nf_d   = !(found_q || hit);
      end else if (sof_q) begin
        done_d = 1'b0;
        nf_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      h_vld_q  <= 1'b0;
      h_word_q <= '0;
      h_addr_q <= '0;
      h_last_q <= 1'b0;
      r_vld_q  <= 1'b0;
      r_word_q <= '0;
      r_addr_q <= '0;
      r_last_q <= 1'b0;
      found_q  <= 1'b0;
      sof_q    <= 1'b1;
      done_q   <= 1'b0;
      nf_q     <= 1'b0;
    end else begin
      h_vld_q  <= h_vld_d;
      h_word_q <= h_word_d;
      h_addr_q <= h_addr_d;
      h_last_q <= h_last_d;
      r_vld_q  <= r_vld_d;
      r_word_q <= r_word_d;
      r_addr_q <= r_addr_d;
      r_last_q <= r_last_d;
      found_q  <= found_d;
      sof_q    <= sof_d;
      done_q   <= done_d;
      nf_q     <= nf_d;
    end
  end

  cpr_readback_check u_readback (
    .clk        (clk),
    .rst_n      (srst_n),
    .capture    (hit),
    .exp_upper  (new_upper),
    .exp_addimm (new_addimm),
    .out_fire   (r_vld_q && out_ready),
    .out_word   (r_word_q),
    .err        (verify_err)
  );

  // little-endian byte view: lowest-addressed byte in the top lane
  for (genvar b = 0; b < NBYTES; b++) begin : g_le
    assign out_le[WORD_W-1-8*b -: 8] = r_word_q[8*b +: 8];
  end

  assign out_valid  = r_vld_q;
  assign out_word   = r_word_q;
  assign out_addr   = r_addr_q;
  assign out_last   = r_last_q;
  assign patch_done = done_q;
  assign not_found  = nf_q;
endmodule

// File: rtl/const_pair_rewriter_chk.sv
module const_pair_rewriter_chk
  import cpr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_last,
  input logic              patch_done,
  input logic              not_found,
  input logic              verify_err
);
  a_r9_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_addr) && $stable(out_last));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(patch_done && not_found));

  a_r7_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    patch_done && !(in_valid && in_ready) |=> patch_done);

  a_r7_nf_held: assert property (@(posedge clk) disable iff (!rst_n)
    not_found && !(in_valid && in_ready) |=> not_found);

  a_r8_no_verify_err: assert property (@(posedge clk) disable iff (!rst_n)
    !verify_err);
endmodule

bind const_pair_rewriter const_pair_rewriter_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/const_pair_rewriter_tb_top.sv
`timescale 1ns/1ps
module const_pair_rewriter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_target;
  logic        in_valid, in_ready, in_last;
  logic [31:0] in_word, in_addr;
  logic        out_valid, out_ready, out_last;
  logic [31:0] out_word, out_le, out_addr;
  logic        patch_done, not_found, verify_err;

  int errors = 0;
  int checks = 0;
  logic bp_en = 1'b0;

  logic [31:0] exp_w[$];
  logic [31:0] exp_a[$];
  logic        exp_l[$];
  string       exp_t[$];

  always #2.5 clk = ~clk;

  const_pair_rewriter #(.ADDR_W(32)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_up(input logic [4:0] rd, input logic [19:0] imm);
    return {imm, rd, 7'h37};
  endfunction

  function automatic logic [31:0] mk_add(input logic [4:0] rd, input logic [4:0] rs, input logic [11:0] imm);
    return {imm, rs, 3'b000, rd, 7'h13};
  endfunction

  // monitor: pops the scoreboard on each transfer
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_w.size() == 0) begin
          check("R5 unexpected word", out_word, 32'hxxxxxxxx);
        end else begin
          logic [31:0] w, a;
          logic l;
          string t;
          w = exp_w.pop_front(); a = exp_a.pop_front();
          l = exp_l.pop_front(); t = exp_t.pop_front();
          check(t, out_word, w);
          check("R5 addr", out_addr, a);
          check("R5 last", {31'b0, out_last}, {31'b0, l});
          check("R6 le view", out_le, {w[7:0], w[15:8], w[23:16], w[31:24]});
        end
      end
    end
  end

  // driver: builds expected stream, then drives it and checks flags
  task automatic send_stream(input logic [31:0] s[16], input int n,
                             input logic [31:0] tgt, input logic [31:0] base);
    logic [31:0] o[16];
    string tg[16];
    logic found;
    logic [19:0] up;
    found = 1'b0;
    for (int i = 0; i < n; i++) begin o[i] = s[i]; tg[i] = "R5 pass-through"; end
    for (int i = 0; i + 1 < n; i++) begin
      if (!found && s[i][6:0] == 7'h37 && s[i+1][6:0] == 7'h13 && s[i+1][14:12] == 3'd0
          && s[i+1][11:7] == s[i][11:7] && s[i+1][19:15] == s[i][11:7]) begin
        up = tgt[31:12] + {19'b0, tgt[11]};
        o[i] = {up, s[i][11:0]};
        o[i+1] = {tgt[11:0], s[i+1][19:0]};
        tg[i] = "R1 R2 R3 upper word";
        tg[i+1] = "R1 R2 R3 add word";
        found = 1'b1;
      end
    end
    for (int i = 0; i < n; i++) begin
      exp_w.push_back(o[i]); exp_a.push_back(base + 4*i);
      exp_l.push_back(i == n-1); exp_t.push_back(tg[i]);
    end
    cfg_target = tgt;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_word = s[i]; in_addr = base + 4*i; in_last = (i == n-1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_w.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
    check("R7 patch_done", {31'b0, patch_done}, {31'b0, found});
    check("R7 not_found", {31'b0, not_found}, {31'b0, !found});
    check("R8 verify_err", {31'b0, verify_err}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] s[16];
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_addr = '0; in_last = 1'b0;
    cfg_target = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R10 out_valid in reset", {31'b0, out_valid}, 32'd0);
    check("R10 patch_done in reset", {31'b0, patch_done}, 32'd0);
    check("R10 not_found in reset", {31'b0, not_found}, 32'd0);
    check("R10 verify_err in reset", {31'b0, verify_err}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // worked example: 0xac0c27b7/0xe0978793 -> 0xbc0c47b7/0xe0178793
    s[0] = 32'h200109b7; s[1] = 32'hac0c27b7; s[2] = 32'he0978793;
    s[3] = 32'hc2f9a823; s[4] = 32'h20011937; s[5] = 32'h00016a99;
    send_stream(s, 6, 32'hbc0c3e01, 32'h0c00);
    // R1 low half below 0x800, no compensation
    s[0] = mk_up(5'd10, 20'h11111); s[1] = mk_add(5'd10, 5'd10, 12'h123); s[2] = 32'h00000013;
    send_stream(s, 3, 32'h12345678, 32'h100);
    // R1 wrap of the upper field
    s[0] = 32'h00000013; s[1] = mk_up(5'd31, 20'h00001); s[2] = mk_add(5'd31, 5'd31, 12'h001);
    s[3] = 32'hdeadbe03;
    send_stream(s, 4, 32'hfffff800, 32'h200);
    // R3 register mismatch
    s[0] = mk_up(5'd5, 20'h12345); s[1] = mk_add(5'd6, 5'd6, 12'h010);
    send_stream(s, 2, 32'h87654321, 32'h300);
    // R3 source differs from destination
    s[0] = mk_up(5'd5, 20'h12345); s[1] = mk_add(5'd5, 5'd6, 12'h010);
    send_stream(s, 2, 32'h87654321, 32'h340);
    // R3 funct3 not zero
    s[0] = mk_up(5'd7, 20'h0abcd); s[1] = mk_add(5'd7, 5'd7, 12'h020) | 32'h00002000;
    send_stream(s, 2, 32'h0badf00d, 32'h380);
    // R3 word in between, then R4 second pair patched because first was not a pair
    s[0] = mk_up(5'd8, 20'h0aaaa); s[1] = 32'h00000013; s[2] = mk_add(5'd8, 5'd8, 12'h555);
    s[3] = mk_up(5'd9, 20'h0bbbb); s[4] = mk_add(5'd9, 5'd9, 12'h777);
    send_stream(s, 5, 32'h00000fff, 32'h400);
    // R4 two pairs, first only
    s[0] = mk_up(5'd1, 20'h00010); s[1] = mk_add(5'd1, 5'd1, 12'h010);
    s[2] = mk_up(5'd2, 20'h00020); s[3] = mk_add(5'd2, 5'd2, 12'h020);
    send_stream(s, 4, 32'hcafe0abc, 32'h500);
    // R5 pair split across the end marker
    s[0] = 32'h00a00093; s[1] = mk_up(5'd12, 20'h33333);
    send_stream(s, 2, 32'h55555555, 32'h600);
    s[0] = mk_add(5'd12, 5'd12, 12'h444); s[1] = 32'h00008067;
    send_stream(s, 2, 32'h55555555, 32'h608);
    // R7 pair ends the stream; single-word stream
    s[0] = 32'h6a996a99; s[1] = mk_up(5'd3, 20'h00000); s[2] = mk_add(5'd3, 5'd3, 12'h000);
    send_stream(s, 3, 32'h80000000, 32'h700);
    s[0] = mk_up(5'd4, 20'h12121);
    send_stream(s, 1, 32'h80000000, 32'h800);

    // R9 random streams under backpressure
    bp_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      int n;
      n = $urandom_range(1, 12);
      for (int i = 0; i < 16; i++) s[i] = $urandom;
      if (n >= 2 && $urandom_range(0, 2) != 0) begin
        int p;
        logic [4:0] rd;
        p = $urandom_range(0, n - 2);
        rd = 5'($urandom_range(0, 31));
        s[p] = mk_up(rd, 20'($urandom));
        s[p+1] = mk_add(rd, rd, 12'($urandom));
      end
      send_stream(s, n, $urandom, 32'h1000 * (k + 1));
    end
    bp_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule